// File: doc/BRIEF.md
# Configuration Frame CRC Checker

This block watches configuration readback data from a group of programmable devices. The data arrives one 16-bit word per accepted cycle and is divided into frames of a fixed number of words. The block walks through the devices in turn. For each device it walks through every frame, and after the last frame of the last device it starts again at the first. A CRC is built up word by word as the data arrives, so the block never stores a whole frame.

When the last word of a frame is accepted, the finished CRC is compared with the expected value for that frame number. The expected value comes from a precomputed table outside the block, which it reads through a simple combinational read port. All devices share one table, because they hold identical configurations.

A mismatch raises an interrupt and latches an error record: the device number, the frame number, both CRC values and a free-running timestamp. The controller can then rewrite only that one frame. While the interrupt is high, the block refuses further readback words. A single acknowledge pulse releases the scan, which goes on with the next frame. A saturating counter keeps the total number of mismatches.

Top module: `frame_crc_checker`

## Requirements
- R1: The frame CRC uses polynomial 0x8005 (x^16+x^15+x^2+1), starts from 0 and has no reflection or final XOR. Each accepted word is shifted in most significant bit first. The CRC covers exactly FRAME_WORDS accepted words and restarts from 0 for the next frame. Cycles in which no word is accepted do not change it.
- R2: `cb_addr` always shows the frame number of the frame being received. `cb_data` is sampled in the cycle in which that frame's last word is accepted.
- R3: When the computed CRC equals `cb_data`, no interrupt is raised and the next frame can start in the very next cycle.
- R4: When they differ, `irq` goes high in the cycle after the last word is accepted, and the error record holds the following:
  - `err_dev` and `err_frame`: the frame's device and frame numbers.
  - `err_calc`: the computed CRC.
  - `err_expect`: the value of `cb_data`.
  - `err_time`: the timestamp counter at that edge. The counter is 0 in the first cycle after reset and counts up by one every cycle.
- R5: While `irq` is high, `word_ready` is 0, offered words are not taken into any CRC, and every error record output holds its value.
- R6: An `irq_ack` pulse while `irq` is high clears `irq` in the next cycle and sets `word_ready` back to 1. An `irq_ack` while `irq` is low has no effect on any output.
- R7: Frames are scanned in the order frame 0 to NUM_FRAMES-1 within a device, and devices in the order 0 to NUM_DEVS-1. After frame NUM_FRAMES-1 of device NUM_DEVS-1 the scan goes to device 0, frame 0.
- R8: `err_count` goes up by one on each mismatch and stays at its all-ones maximum once it reaches it.
- R9: After reset, `irq` is 0, `word_ready` is 1, `err_count` is 0 and the error record is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | A readback word is offered |
| word_data | input | 16 | Readback word |
| word_ready | output | 1 | The word is accepted this cycle when valid |
| cb_addr | output | $clog2(NUM_FRAMES) | Frame number used to read the expected-CRC table |
| cb_data | input | 16 | Expected CRC for `cb_addr` |
| irq | output | 1 | Mismatch interrupt, held until acknowledged |
| irq_ack | input | 1 | Acknowledge pulse from the controller |
| err_dev | output | $clog2(NUM_DEVS) | Device number of the failing frame |
| err_frame | output | $clog2(NUM_FRAMES) | Frame number of the failing frame |
| err_calc | output | 16 | CRC computed over the failing frame |
| err_expect | output | 16 | Expected CRC read from the table |
| err_time | output | TS_W | Timestamp of the mismatch |
| err_count | output | CNT_W | Saturating count of mismatches |

## Verification
Assertions check these on every cycle:
- the word counter stays within the frame length;
- the scan order steps correctly and wraps back to the start;
- no frame can end while the interrupt is pending;
- the interrupt rises only on a frame-end mismatch, and an acknowledge clears it;
- the error record stays frozen while the interrupt is high;
- the counter holds at its maximum.

Only the bench's scenarios can show the rest: that the CRC value itself is right for clean, corrupted and gapped frames; that words offered during a stall leave no trace in the next frame; that a stray acknowledge changes nothing; and that the timestamp and device/frame fields name the right frame after the scan wraps.

// File: rtl/crcchk_pkg.sv
package crcchk_pkg;

  localparam int CRC_W = 16;
  typedef logic [CRC_W-1:0] crc_t;

  localparam crc_t CRC_POLY = 16'h8005;
  localparam crc_t CRC_SEED = 16'h0000;

  // Serial MSB-first update, one data bit per step.
  function automatic crc_t crc16_step(input crc_t crc, input crc_t word);
    crc_t c;
    logic fb;
    c = crc;
    for (int i = CRC_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ word[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/crc_accum.sv
module crc_accum
  import crcchk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic last,
  input  crc_t word,
  output crc_t crc_final
);

  crc_t crc_q;

  assign crc_final = crc16_step(crc_q, word);

  always_ff @(posedge clk) begin
    if (!rst_n)            crc_q <= CRC_SEED;
    else if (take && last) crc_q <= CRC_SEED;
    else if (take)         crc_q <= crc_final;
  end

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import crcchk_pkg::*;
#(
  parameter int FRAME_WORDS = 8,
  parameter int NUM_FRAMES  = 4,
  parameter int NUM_DEVS    = 3,
  localparam int WIDX_W = idx_width(FRAME_WORDS),
  localparam int FIDX_W = idx_width(NUM_FRAMES),
  localparam int DIDX_W = idx_width(NUM_DEVS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  output logic              last_word,
  output logic [FIDX_W-1:0] frame_idx,
  output logic [DIDX_W-1:0] dev_idx
);

  localparam logic [WIDX_W-1:0] WLAST = WIDX_W'(FRAME_WORDS - 1);
  localparam logic [FIDX_W-1:0] FLAST = FIDX_W'(NUM_FRAMES - 1);
  localparam logic [DIDX_W-1:0] DLAST = DIDX_W'(NUM_DEVS - 1);

  logic [WIDX_W-1:0] word_idx;
  logic frame_end, dev_end;

  assign last_word = (word_idx == WLAST);
  assign frame_end = take && last_word;
  assign dev_end   = frame_end && (frame_idx == FLAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_idx  <= '0;
      frame_idx <= '0;
      dev_idx   <= '0;
    end else if (take) begin
      word_idx <= last_word ? '0 : word_idx + 1'b1;
      if (frame_end) frame_idx <= (frame_idx == FLAST) ? '0 : frame_idx + 1'b1;
      if (dev_end)   dev_idx   <= (dev_idx == DLAST) ? '0 : dev_idx + 1'b1;
    end
  end

  // R1
  word_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(word_idx) < FRAME_WORDS);

  // R7
  scan_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_end && dev_idx == DLAST) |=> (dev_idx == '0 && frame_idx == '0));

  // R7
  frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && frame_idx != FLAST) |=>
      (int'(frame_idx) == int'($past(frame_idx)) + 1 && $stable(dev_idx)));

endmodule

// File: rtl/err_recorder.sv
module err_recorder
  import crcchk_pkg::*;
#(
  parameter int FIDX_W = 2,
  parameter int DIDX_W = 2,
  parameter int TS_W   = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  crc_t              calc,
  input  crc_t              expect_crc,
  input  logic [DIDX_W-1:0] dev,
  input  logic [FIDX_W-1:0] frame,
  input  logic              ack,
  output logic              irq,
  output logic [DIDX_W-1:0] rec_dev,
  output logic [FIDX_W-1:0] rec_frame,
  output crc_t              rec_calc,
  output crc_t              rec_expect,
  output logic [TS_W-1:0]   rec_time,
  output logic [CNT_W-1:0]  mis_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [TS_W-1:0] ts;
  logic mismatch_ev;

  assign mismatch_ev = frame_end && (calc != expect_crc);

  always_ff @(posedge clk) begin
    if (!rst_n) ts <= '0;
    else        ts <= ts + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq        <= 1'b0;
      rec_dev    <= '0;
      rec_frame  <= '0;
      rec_calc   <= '0;
      rec_expect <= '0;
      rec_time   <= '0;
      mis_count  <= '0;
    end else if (mismatch_ev) begin
      irq        <= 1'b1;
      rec_dev    <= dev;
      rec_frame  <= frame;
      rec_calc   <= calc;
      rec_expect <= expect_crc;
      rec_time   <= ts;
      if (mis_count != CNT_MAX) mis_count <= mis_count + 1'b1;
    end else if (irq && ack) begin
      irq <= 1'b0;
    end
  end

  // R4
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mismatch_ev));

  // R5
  record_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq) && irq) |-> ($stable(rec_dev) && $stable(rec_frame) &&
      $stable(rec_calc) && $stable(rec_expect) && $stable(rec_time)));

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && ack) |=> !irq);

  // R8
  count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mis_count == CNT_MAX) |=> (mis_count == CNT_MAX));

endmodule

// File: rtl/frame_crc_checker.sv
module frame_crc_checker
  import crcchk_pkg::*;
#(
  parameter int FRAME_WORDS = 8,
  parameter int NUM_FRAMES  = 4,
  parameter int NUM_DEVS    = 3,
  parameter int TS_W        = 32,
  parameter int CNT_W       = 16,
  localparam int FIDX_W = idx_width(NUM_FRAMES),
  localparam int DIDX_W = idx_width(NUM_DEVS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [15:0]       word_data,
  output logic              word_ready,
  output logic [FIDX_W-1:0] cb_addr,
  input  logic [15:0]       cb_data,
  output logic              irq,
  input  logic              irq_ack,
  output logic [DIDX_W-1:0] err_dev,
  output logic [FIDX_W-1:0] err_frame,
  output logic [15:0]       err_calc,
  output logic [15:0]       err_expect,
  output logic [TS_W-1:0]   err_time,
  output logic [CNT_W-1:0]  err_count
);

  logic word_take, last_word, frame_end;
  logic [FIDX_W-1:0] frame_idx;
  logic [DIDX_W-1:0] dev_idx;
  crc_t crc_final;

  assign word_ready = !irq;
  assign word_take  = word_valid && word_ready;
  assign frame_end  = word_take && last_word;
  assign cb_addr    = frame_idx;

  scan_sequencer #(
    .FRAME_WORDS(FRAME_WORDS),
    .NUM_FRAMES (NUM_FRAMES),
    .NUM_DEVS   (NUM_DEVS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (word_take),
    .last_word(last_word),
    .frame_idx(frame_idx),
    .dev_idx  (dev_idx)
  );

  crc_accum u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (word_take),
    .last     (last_word),
    .word     (word_data),
    .crc_final(crc_final)
  );

  err_recorder #(
    .FIDX_W(FIDX_W),
    .DIDX_W(DIDX_W),
    .TS_W  (TS_W),
    .CNT_W (CNT_W)
  ) u_rec (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .calc      (crc_final),
    .expect_crc(cb_data),
    .dev       (dev_idx),
    .frame     (frame_idx),
    .ack       (irq_ack),
    .irq       (irq),
    .rec_dev   (err_dev),
    .rec_frame (err_frame),
    .rec_calc  (err_calc),
    .rec_expect(err_expect),
    .rec_time  (err_time),
    .mis_count (err_count)
  );

  // R5
  no_frame_end_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !frame_end);

endmodule

// File: tb/frame_crc_checker_tb.sv
module frame_crc_checker_tb;

  localparam int FW = 8;
  localparam int NF = 4;
  localparam int ND = 3;
  localparam int TSW = 32;
  localparam int CW = 3;
  localparam int FAW = $clog2(NF);
  localparam int DAW = $clog2(ND);
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_valid = 1'b0;
  logic [15:0] word_data = '0;
  logic word_ready;
  logic [FAW-1:0] cb_addr;
  logic [15:0] cb_data;
  logic irq;
  logic irq_ack = 1'b0;
  logic [DAW-1:0] err_dev;
  logic [FAW-1:0] err_frame;
  logic [15:0] err_calc, err_expect;
  logic [TSW-1:0] err_time;
  logic [CW-1:0] err_count;

  always #10 clk = ~clk;

  frame_crc_checker #(
    .FRAME_WORDS(FW), .NUM_FRAMES(NF), .NUM_DEVS(ND), .TS_W(TSW), .CNT_W(CW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
    .word_ready(word_ready), .cb_addr(cb_addr), .cb_data(cb_data), .irq(irq),
    .irq_ack(irq_ack), .err_dev(err_dev), .err_frame(err_frame),
    .err_calc(err_calc), .err_expect(err_expect), .err_time(err_time),
    .err_count(err_count)
  );

  logic [15:0] cb_mem [NF];
  assign cb_data = cb_mem[cb_addr];

  typedef struct {
    int dev; int frame; logic [15:0] calc; logic [15:0] expv; longint ts;
  } rec_t;
  rec_t exp_q[$];

  int checks = 0, failures = 0;
  bit done = 0;
  longint cyc = 0;
  int pos_dev = 0, pos_frame = 0, exp_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Whole-word form: fold the word in, then shift sixteen times.
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] w);
    logic [15:0] r;
    r = c ^ w;
    repeat (16) r = r[15] ? ((r << 1) ^ 16'h8005) : (r << 1);
    return r;
  endfunction

  function automatic logic [15:0] frame_word(input int f, input int k);
    return 16'hA5C3 ^ 16'(f * 16'h1357) ^ 16'(k * 16'h0F1F);
  endfunction

  // Driver: sends one frame at the bench's idea of the scan position.
  task automatic send_frame(input int bad_word, input bit gaps);
    logic [15:0] c, w;
    c = 16'h0000;
    for (int k = 0; k < FW; k++) begin
      @(negedge clk);
      if (k == 0)
        chk(int'(cb_addr) == pos_frame, "R2", "cb_addr at frame start", cb_addr, pos_frame);
      w = frame_word(pos_frame, k);
      if (k == bad_word) w = w ^ 16'h0040;
      c = ref_crc(c, w);
      word_valid = 1'b1;
      word_data  = w;
      if (k == FW - 1 && bad_word >= 0)
        exp_q.push_back('{pos_dev, pos_frame, c, cb_mem[pos_frame], cyc});
      if (gaps && k != FW - 1) begin
        @(negedge clk);
        word_valid = 1'b0;
      end
    end
    @(negedge clk);
    word_valid = 1'b0;
    if (bad_word >= 0 && exp_cnt < CMAX) exp_cnt++;
    pos_frame++;
    if (pos_frame == NF) begin
      pos_frame = 0;
      pos_dev = (pos_dev + 1) % ND;
    end
  endtask

  // Called at the negedge just after a corrupted frame.
  task automatic service_irq(input int stall);
    logic [15:0] s_calc;
    longint s_time;
    int s_frame;
    chk(irq == 1'b1, "R4", "irq after mismatch", irq, 1);
    s_calc = err_calc; s_time = err_time; s_frame = err_frame;
    for (int i = 0; i < stall; i++) begin
      word_valid = 1'b1;
      word_data  = 16'hDEAD + 16'(i);
      @(negedge clk);
      chk(word_ready == 1'b0, "R5", "ready during stall", word_ready, 0);
      chk(err_calc == s_calc && err_time == s_time && int'(err_frame) == s_frame,
          "R5", "record held", err_calc, s_calc);
    end
    word_valid = 1'b0;
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk(irq == 1'b0, "R6", "irq cleared by ack", irq, 0);
    chk(word_ready == 1'b1, "R6", "ready after ack", word_ready, 1);
    chk(int'(err_count) == exp_cnt, "R8", "mismatch count", err_count, exp_cnt);
  endtask

  // Monitor: pops the scoreboard on each rising interrupt.
  logic prev_irq = 1'b0;
  always @(negedge clk) begin
    if (rst_n && irq && !prev_irq) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3", "unexpected irq", 1, 0);
      end else begin
        rec_t e;
        e = exp_q.pop_front();
        chk(int'(err_dev) == e.dev, "R4", "err_dev", err_dev, e.dev);
        chk(int'(err_frame) == e.frame, "R4", "err_frame", err_frame, e.frame);
        chk(err_calc == e.calc, "R1", "err_calc", err_calc, e.calc);
        chk(err_expect == e.expv, "R4", "err_expect", err_expect, e.expv);
        chk(longint'(err_time) == e.ts, "R4", "err_time", err_time, e.ts);
      end
    end
    prev_irq <= irq;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < NF; f++) begin
      logic [15:0] c;
      c = 16'h0000;
      for (int k = 0; k < FW; k++) c = ref_crc(c, frame_word(f, k));
      cb_mem[f] = c;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(irq == 1'b0, "R9", "irq after reset", irq, 0);
    chk(word_ready == 1'b1, "R9", "ready after reset", word_ready, 1);
    chk(err_count == '0, "R9", "count after reset", err_count, 0);
    chk(err_calc == '0 && err_time == '0, "R9", "record after reset", err_calc, 0);

    // R3: a clean full pass, including the device wrap
    for (int i = 0; i < NF * ND; i++) send_frame(-1, 1'b0);
    chk(irq == 1'b0 && err_count == '0, "R3", "clean pass has no irq", err_count, 0);

    // R4/R5/R6: corrupt device 0 frame 1, stall with words offered
    send_frame(-1, 1'b0);
    send_frame(3, 1'b0);
    service_irq(4);
    // R5: words offered in the stall must not pollute the next frame
    send_frame(-1, 1'b0);
    chk(irq == 1'b0, "R5", "stall words ignored", irq, 0);

    // R6: stray ack has no effect
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0 && word_ready == 1'b1, "R6", "stray ack irq/ready", irq, 0);
    chk(int'(err_count) == exp_cnt, "R6", "stray ack count", err_count, exp_cnt);

    // R1: gapped clean frame, then gapped corrupted frame
    send_frame(-1, 1'b1);
    send_frame(0, 1'b1);
    service_irq(1);

    // R7: move to the last frame of the last device, corrupt it and the next one
    while (!(pos_dev == ND - 1 && pos_frame == NF - 1)) send_frame(-1, 1'b0);
    send_frame(FW - 1, 1'b0);
    service_irq(0);
    chk(int'(err_dev) == ND - 1 && int'(err_frame) == NF - 1, "R7", "last dev/frame",
        err_frame, NF - 1);
    send_frame(5, 1'b0);
    service_irq(2);
    chk(err_dev == '0 && err_frame == '0, "R7", "wrap to dev0 frame0", err_dev, 0);

    // R8: saturate the counter
    for (int i = 0; i < CMAX + 2; i++) begin
      send_frame(i % FW, 1'b0);
      service_irq(0);
    end
    chk(int'(err_count) == CMAX, "R8", "count saturated", err_count, CMAX);
    chk(exp_q.size() == 0, "R4", "all expected interrupts seen", exp_q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule